// File: doc/BRIEF.md
# Cipher Block DMA Word Sequencer

This block connects a 32-bit register port to a 128-bit block cipher core. In the input phase it collects four 32-bit writes into one 128-bit block, with the most significant word first. When a DMA engine is allowed to move the data, the block raises one single-word write request for each word. After the fourth word it gives the core a one-cycle start pulse and waits for the core's done pulse. In the output phase it captures the 128-bit result and hands it back one word at a time, again most significant word first. When a DMA engine is allowed, the block raises one single-word read request for each word. After the fourth read it returns to the input phase on its own, so a stream of blocks runs with no software action between blocks.

DMA requests are gated by the operating mode. Only the encrypt code (1) and the decrypt code (3) let them through. In the key-derivation code (2), and in code 0, the two DMA enables have no effect. Software can always move the data directly through the same write and read ports, with the same word order and the same phase sequence. Clearing the block enable drops every request at once and puts the sequencer back into the empty input phase.

States: `PH_IN` (collecting input words), `PH_GO` (start pulse), `PH_WAIT` (core busy), `PH_OUT` (serving result words). Transitions: `PH_IN`→`PH_GO` on the fourth accepted write, `PH_GO`→`PH_WAIT` always, `PH_WAIT`→`PH_OUT` on core done, `PH_OUT`→`PH_IN` on the fourth accepted read, any state→`PH_IN` with the word count cleared when `en` is low.

Top module: `cipher_word_seq`

## Requirements
- R1: The block presented on `core_in` holds the 1st accepted write in bits 127:96, the 2nd in 95:64, the 3rd in 63:32 and the 4th in 31:0, with no byte or bit swapping.
- R2: In the cycle after the fourth accepted write, `core_start` is high, and it stays high for exactly one cycle.
- R3: After `core_done`, the block captures `core_out` and enters the output phase. There `rd_data` shows bits 127:96 first and bits 31:0 last, and each `rd_strobe` moves to the next word.
- R4: After the fourth accepted read, the block returns to the input phase with no software action and accepts the next block. `rd_data` is then 0.
- R5: `req_wr` is high in the input phase when `en` and `dma_in_en` are set and `mode` is 1 or 3. `req_rd` is high in the output phase under the same mode condition with `dma_out_en` set. The two are never high together.
- R6: A request stays high until the matching access is accepted, then is low for at least the next cycle.
- R7: With `mode` equal to 2 or 0, neither request is ever raised whatever the enables are, and direct register access still sequences blocks correctly.
- R8: With `en` low, both requests and `core_start` are low in the same cycle, writes and reads are ignored, and the next cycle finds the input phase with the word count at zero.
- R9: A write outside the input phase or a read strobe outside the output phase has no effect. `rd_data` is 0 outside the output phase.
- R10: After reset, the block is in the input phase at word 0, with `core_start` low and `rd_data` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low aborts and returns to input phase |
| mode | input | 2 | Operating mode: 1 encrypt, 3 decrypt, 2 key derivation |
| dma_in_en | input | 1 | Allow write DMA requests |
| dma_out_en | input | 1 | Allow read DMA requests |
| wr_valid | input | 1 | Write strobe for the data-input register |
| wr_data | input | 32 | Data-input word |
| rd_strobe | input | 1 | Read strobe for the data-output register (advances the word) |
| rd_data | output | 32 | Current data-output word, 0 outside the output phase |
| req_wr | output | 1 | Single-word DMA write request |
| req_rd | output | 1 | Single-word DMA read request |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_in | output | 128 | Packed input block |
| core_done | input | 1 | One-cycle done pulse from the cipher core |
| core_out | input | 128 | Result block, valid with `core_done` |

## Verification
On every cycle, the assertions check that the two requests are never high together, and that no request appears in modes 2 or 0. They also check that an accepted access is followed by a low request, that the start pulse is single and follows the fourth write, and that the sequencer wraps to input after the fourth read or after `en` drops. Only the bench scenarios can show the data path itself. These cover the word position of each write in the packed block and the order in which result words come back. They also show that stray accesses in the wrong phase leave both unchanged, and that an aborted block does not leak into the next one.

// File: rtl/cws_pkg.sv
package cws_pkg;
    typedef enum logic [1:0] {
        PH_IN   = 2'd0,
        PH_GO   = 2'd1,
        PH_WAIT = 2'd2,
        PH_OUT  = 2'd3
    } phase_e;

    localparam logic [1:0] MODE_ENC = 2'd1;
    localparam logic [1:0] MODE_DEC = 2'd3;
endpackage

// File: rtl/cws_fsm.sv
module cws_fsm
    import cws_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_valid,
    input  logic             rd_strobe,
    input  logic             core_done,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             wr_take,
    output logic             rd_take,
    output logic             done_take,
    output logic             core_start,
    output logic             gap
);
    phase_e           nxt;
    logic [CNT_W-1:0] cnt_n;
    logic             last;

    assign last = (cnt == CNT_W'(WORDS - 1));

    // accept strobes
    always_comb begin
        wr_take    = en && (phase == PH_IN)   && wr_valid;
        rd_take    = en && (phase == PH_OUT)  && rd_strobe;
        done_take  = en && (phase == PH_WAIT) && core_done;
        core_start = en && (phase == PH_GO);
    end

    // next-state logic
    always_comb begin
        nxt   = phase;
        cnt_n = cnt;
        unique case (phase)
            PH_IN: begin
                if (wr_take) begin
                    if (last) begin
                        nxt   = PH_GO;
                        cnt_n = '0;
                    end else begin
                        cnt_n = CNT_W'(cnt + 1'b1);
                    end
                end
            end
            PH_GO:   nxt = PH_WAIT;
            PH_WAIT: if (done_take) nxt = PH_OUT;
            PH_OUT: begin
                if (rd_take) begin
                    if (last) begin
                        nxt   = PH_IN;
                        cnt_n = '0;
                    end else begin
                        cnt_n = CNT_W'(cnt + 1'b1);
                    end
                end
            end
            default: nxt = PH_IN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IN;
            cnt   <= '0;
            gap   <= 1'b0;
        end else if (!en) begin
            phase <= PH_IN;
            cnt   <= '0;
            gap   <= 1'b0;
        end else begin
            phase <= nxt;
            cnt   <= cnt_n;
            gap   <= wr_take || rd_take;
        end
    end

    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);
    a_r2_start_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && last) |=> (core_start || !en));
    a_r4_wrap_to_input: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && last) |=> (phase == PH_IN && cnt == '0));
    a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase == PH_IN && cnt == '0));
endmodule

// File: rtl/cws_pack.sv
module cws_pack #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int BLK_W = WORD_W * WORDS,
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_take,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [WORD_W-1:0] wr_data,
    output logic [BLK_W-1:0]  blk
);
    // slot g holds the g-th word written; slot 0 lands at the top of the block
    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   slot <= '0;
            else if (wr_take && cnt == CNT_W'(g))         slot <= wr_data;
        end
        assign blk[BLK_W-1-g*WORD_W -: WORD_W] = slot;
    end
endmodule

// File: rtl/cws_unpack.sv
module cws_unpack #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int BLK_W = WORD_W * WORDS,
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BLK_W-1:0]  core_out,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              valid,
    output logic [WORD_W-1:0] rd_data
);
    logic [BLK_W-1:0]  res;
    logic [WORD_W-1:0] w [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    res <= '0;
        else if (load) res <= core_out;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign w[g] = res[BLK_W-1-g*WORD_W -: WORD_W];
    end

    always_comb begin
        rd_data = '0;
        if (valid) rd_data = w[cnt];
    end
endmodule

// File: rtl/cipher_word_seq.sv
module cipher_word_seq
    import cws_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int BLK_W = WORD_W * WORDS,
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic              dma_in_en,
    input  logic              dma_out_en,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              req_wr,
    output logic              req_rd,
    output logic              core_start,
    output logic [BLK_W-1:0]  core_in,
    input  logic              core_done,
    input  logic [BLK_W-1:0]  core_out
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             wr_take, rd_take, done_take, gap;
    logic             mode_ok;

    cws_fsm #(.WORDS(WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en),
        .wr_valid(wr_valid), .rd_strobe(rd_strobe), .core_done(core_done),
        .phase(phase), .cnt(cnt),
        .wr_take(wr_take), .rd_take(rd_take), .done_take(done_take),
        .core_start(core_start), .gap(gap)
    );

    cws_pack #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pack (
        .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .cnt(cnt),
        .wr_data(wr_data), .blk(core_in)
    );

    cws_unpack #(.WORD_W(WORD_W), .WORDS(WORDS)) u_unpack (
        .clk(clk), .rst_n(rst_n), .load(done_take), .core_out(core_out),
        .cnt(cnt), .valid(phase == PH_OUT), .rd_data(rd_data)
    );

    // request generation: mode gate, phase gate, one-cycle gap after each access
    always_comb begin
        mode_ok = en && (mode == MODE_ENC || mode == MODE_DEC);
        req_wr  = mode_ok && dma_in_en  && (phase == PH_IN)  && !gap;
        req_rd  = mode_ok && dma_out_en && (phase == PH_OUT) && !gap;
    end

    a_r5_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_wr, req_rd}));
    a_r7_mode_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 || mode == 2'd0) |-> (!req_wr && !req_rd));
    a_r6_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> !req_wr);
    a_r6_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> !req_rd);
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!req_wr && !req_rd && !core_start));
endmodule

// File: tb/tb_cipher_word_seq.sv
`timescale 1ns/1ps
module tb_cipher_word_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [1:0]   mode = 2'd1;
    logic         dma_in_en = 1'b0, dma_out_en = 1'b0;
    logic         wr_valid = 1'b0;
    logic [31:0]  wr_data = '0;
    logic         rd_strobe = 1'b0;
    logic [31:0]  rd_data;
    logic         req_wr, req_rd, core_start;
    logic [127:0] core_in;
    logic         core_done = 1'b0;
    logic [127:0] core_out = '0;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cipher_word_seq dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .dma_in_en(dma_in_en), .dma_out_en(dma_out_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .req_wr(req_wr), .req_rd(req_rd),
        .core_start(core_start), .core_in(core_in),
        .core_done(core_done), .core_out(core_out)
    );

    function automatic logic [127:0] fcore(logic [127:0] x);
        return ~x ^ {4{32'h5A3C96E1}};
    endfunction

    function automatic logic [31:0] wsel(logic [127:0] b, int i);
        return b[127-32*i -: 32];
    endfunction

    // core stub: captures input at start, answers 1..3 cycles later
    logic [127:0] cap = '0;
    int  dly = 0;
    bit  pend = 0;
    logic prev_start = 1'b0;
    int  dbl_start = 0;
    always @(posedge clk) begin
        core_done <= 1'b0;
        prev_start <= core_start;
        if (core_start && prev_start) dbl_start <= dbl_start + 1;
        if (core_start) begin
            cap  <= core_in;
            dly  <= 1 + int'($urandom % 3);
            pend <= 1;
        end else if (pend) begin
            if (dly <= 1) begin
                core_done <= 1'b1;
                core_out  <= fcore(cap);
                pend      <= 0;
            end else dly <= dly - 1;
        end
    end

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_req(bit rd);
        for (int k = 0; k < 40; k++) begin
            if (rd ? req_rd : req_wr) break;
            @(negedge clk);
        end
        chk(rd ? req_rd : req_wr, "R5 request raised", 0, 1);
    endtask

    task automatic run_block(logic [127:0] blk, logic [1:0] md, bit din, bit dout, bit spur);
        bit ok;
        ok = (md == 2'd1 || md == 2'd3);
        mode = md; dma_in_en = din; dma_out_en = dout;
        for (int i = 0; i < 4; i++) begin
            if (din && ok) wait_req(0);
            else chk(req_wr == 1'b0, "R7 write request gated off", req_wr, 0);
            wr_valid = 1'b1; wr_data = wsel(blk, i);
            @(negedge clk);
            wr_valid = 1'b0;
            if (i < 3) begin
                chk(req_wr == 1'b0, "R6 gap after write", req_wr, 0);
                if (spur && i == 1) begin
                    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
                    chk(rd_data == 32'd0, "R9 rd_data zero in input phase", rd_data, 0);
                end
            end else begin
                chk(core_start == 1'b1, "R2 start after fourth write", core_start, 1);
                @(negedge clk);
                chk(core_start == 1'b0, "R2 start lasts one cycle", core_start, 0);
            end
        end
        if (spur) begin
            wr_valid = 1'b1; wr_data = 32'hDEADBEEF; @(negedge clk); wr_valid = 1'b0;
        end
        for (int k = 0; k < 20 && !core_done; k++) @(negedge clk);
        chk(cap == blk, "R1 packed word order", cap, blk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (dout && ok) wait_req(1);
            else chk(req_rd == 1'b0, "R7 read request gated off", req_rd, 0);
            chk(rd_data == wsel(fcore(blk), i), "R3 output word order",
                rd_data, wsel(fcore(blk), i));
            rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
            if (i < 3) chk(req_rd == 1'b0, "R6 gap after read", req_rd, 0);
            else       chk(rd_data == 32'd0, "R4 back in input phase", rd_data, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(rd_data == 0 && core_start == 0, "R10 reset outputs", {rd_data, core_start}, 0);
        rst_n = 1'b1; en = 1'b1; mode = 2'd1; dma_in_en = 1'b1;
        #1;
        chk(req_wr == 1'b1 && req_rd == 1'b0, "R10 input phase after reset", {req_wr, req_rd}, 2'b10);
        @(negedge clk);

        run_block(128'h00112233_44556677_8899AABB_CCDDEEFF, 2'd1, 1, 1, 0);
        run_block(128'hFFFFFFFF_00000000_FFFFFFFF_00000000, 2'd3, 0, 0, 1);
        run_block(128'h01234567_89ABCDEF_FEDCBA98_76543210, 2'd2, 1, 1, 0);
        run_block(128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C, 2'd0, 1, 1, 1);

        // R8: abort mid-block
        mode = 2'd1; dma_in_en = 1'b1; dma_out_en = 1'b1;
        for (int i = 0; i < 2; i++) begin
            wait_req(0);
            wr_valid = 1'b1; wr_data = 32'hBAD0_0000 | i; @(negedge clk); wr_valid = 1'b0;
        end
        en = 1'b0; #1;
        chk(req_wr == 0 && req_rd == 0 && core_start == 0, "R8 requests drop with en", req_wr, 0);
        wr_valid = 1'b1; wr_data = 32'hCAFEF00D; @(negedge clk); wr_valid = 1'b0;
        en = 1'b1; @(negedge clk);
        run_block(128'h11111111_22222222_33333333_44444444, 2'd1, 1, 1, 0);

        for (int n = 0; n < 40; n++) begin
            logic [127:0] b;
            logic [1:0] md;
            b = {$urandom, $urandom, $urandom, $urandom};
            md = 2'($urandom % 4);
            run_block(b, md, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        chk(dbl_start == 0, "R2 no back-to-back starts", dbl_start, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule